// File: doc/BRIEF.md
# Burst Address Generator with Dual Strobes

This block is the address front end of a synchronous burst memory. On a rising clock edge where either of two active-low address strobes is low and the chip is selected, it captures a full word address. It then presents that address as the first beat of a four-beat burst. On each later edge where the active-low advance input is low, a two-bit beat counter steps and the two lowest address bits move to the next beat. The upper address bits stay fixed for the whole burst.

A mode input chooses the beat order. When it is high, the low bits are the start bits XORed with the beat number (interleaved order). When it is low, the low bits are the start bits plus the beat number, modulo four (linear order). The mode is sampled on the same edge as the address. Chip selection is the AND of three enables: one active low, one active high and one more active low. A strobe while the chip is deselected captures nothing and drops the valid flag. A strobe in the middle of a burst starts a new burst at once.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears the valid flag, the beat counter and the held address, so `addr_out` reads 0 and `valid` reads 0 on the edge after reset.
- R2: On an edge where `cpu_stb_n` or `ctl_stb_n` is 0 and the chip is selected (`sel_n`=0, `sel_hi`=1, `sel_lo_n`=0), `addr_out` equals the sampled `addr_in` and `valid` is 1 after that edge. Either strobe alone is enough.
- R3: A strobe on an edge where any enable is inactive captures no address and leaves `valid` at 0 after that edge.
- R4: With `valid`=1 and no strobe, the beat advances by one on each edge where `adv_n`=0. On each edge where `adv_n`=1, `addr_out` holds for any number of cycles.
- R5: With `order_il`=1 at capture, the two low bits of beat k (k=0..3) equal the start low bits XOR k.
- R6: With `order_il`=0 at capture, the two low bits of beat k equal (start low bits + k) mod 4.
- R7: Bits above bit 1 of `addr_out` never change between strobes.
- R8: Advancing from the fourth beat returns `addr_out` to the start address.
- R9: A qualified strobe in the middle of a burst restarts at beat 0 with the new address, and takes priority over advance.
- R10: With `valid`=0, asserting `adv_n` without a strobe leaves `valid` at 0 and `addr_out` unchanged.
- R11: The order is taken from `order_il` at capture. Changes to `order_il` during a burst have no effect on the beat sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_stb_n | input | 1 | First address strobe, active low |
| ctl_stb_n | input | 1 | Second address strobe, active low |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_il | input | 1 | 1 selects interleaved order, 0 selects linear order |
| sel_n | input | 1 | Chip enable, active low |
| sel_hi | input | 1 | Depth-expansion enable, active high |
| sel_lo_n | input | 1 | Depth-expansion enable, active low |
| addr_in | input | ADDR_W | Word address captured on a qualified strobe |
| addr_out | output | ADDR_W | Current beat address |
| valid | output | 1 | A burst address is being presented |

## Verification
A corrupted beat counter or a wrong stored order shows up in the low two bits of `addr_out` on the first edge after the bad update. The sweep compares every beat of every start offset, in both orders, against the XOR and modulo-sum formulas, so such an error is caught within one cycle. A bad enable decode or a bad strobe priority shows up on the edge after the strobe, either as a wrong `valid` or as an address that did not reload. A hold fault shows as an address that moves while advance is high, and the checks across several idle cycles expose it in the first moving cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Low address bits for a given beat of the burst.
  function automatic logic [BEAT_W-1:0] beat_low(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input order_e            ord
  );
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/burst_strobe_dec.sv
module burst_strobe_dec (
  input  logic cpu_stb_n,
  input  logic ctl_stb_n,
  input  logic sel_n,
  input  logic sel_hi,
  input  logic sel_lo_n,
  output logic stb_any,
  output logic chip_hit,
  output logic load_ev,
  output logic drop_ev
);
  always_comb begin
    stb_any  = ~cpu_stb_n | ~ctl_stb_n;
    chip_hit = ~sel_n & sel_hi & ~sel_lo_n;
    load_ev  = stb_any & chip_hit;
    drop_ev  = stb_any & ~chip_hit;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              adv_n,
  input  logic              order_il,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              valid
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic stb_any, chip_hit, load_ev, drop_ev, adv_ev;
  logic [UP_W-1:0]   base_up;
  logic [BEAT_W-1:0] base_lo;
  logic [BEAT_W-1:0] beat;
  order_e            ord_q;

  burst_strobe_dec u_dec (
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .sel_n     (sel_n),
    .sel_hi    (sel_hi),
    .sel_lo_n  (sel_lo_n),
    .stb_any   (stb_any),
    .chip_hit  (chip_hit),
    .load_ev   (load_ev),
    .drop_ev   (drop_ev)
  );

  assign adv_ev = valid & ~adv_n & ~stb_any;

  burst_beat_ctr #(.W(BEAT_W)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .clr  (load_ev),
    .step (adv_ev),
    .cnt  (beat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      base_up <= '0;
      base_lo <= '0;
      ord_q   <= ORD_LINEAR;
    end else if (load_ev) begin
      valid   <= 1'b1;
      base_up <= addr_in[ADDR_W-1:BEAT_W];
      base_lo <= addr_in[BEAT_W-1:0];
      ord_q   <= order_e'(order_il);
    end else if (drop_ev) begin
      valid   <= 1'b0;
    end
  end

  assign addr_out = {base_up, beat_low(base_lo, beat, ord_q)};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              adv_n,
  input logic              stb_any,
  input logic              load_ev,
  input logic              drop_ev,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic              valid
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!valid && addr_out == '0)); // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> (valid && addr_out == $past(addr_in))); // R2

  AST_DESELECT_DROP: assert property (@(posedge clk) disable iff (rst)
    drop_ev |=> !valid); // R3

  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (rst)
    (valid && !stb_any && adv_n) |=> $stable(addr_out)); // R4

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    !stb_any |=> $stable(addr_out[ADDR_W-1:2])); // R7

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!valid && !stb_any) |=> (!valid && $stable(addr_out))); // R10
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .adv_n    (adv_n),
  .stb_any  (stb_any),
  .load_ev  (load_ev),
  .drop_ev  (drop_ev),
  .addr_in  (addr_in),
  .addr_out (addr_out),
  .valid    (valid)
);

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;

  logic clk = 1'b0;
  logic rst, cpu_stb_n, ctl_stb_n, adv_n, order_il, sel_n, sel_hi, sel_lo_n;
  logic [AW-1:0] addr_in, addr_out;
  logic valid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
    .adv_n(adv_n), .order_il(order_il), .sel_n(sel_n), .sel_hi(sel_hi),
    .sel_lo_n(sel_lo_n), .addr_in(addr_in), .addr_out(addr_out), .valid(valid)
  );

  // Expected low bits, computed bit by bit for interleave, by integer sum for linear.
  function automatic int exp_low(int s, int k, bit il);
    int r = 0;
    if (il) begin
      for (int b = 0; b < 2; b++)
        if (((s >> b) & 1) != ((k >> b) & 1)) r += (1 << b);
    end else r = (s + k) % 4;
    return r;
  endfunction

  task automatic chk(string req, logic [AW-1:0] ea, logic ev);
    checks++;
    if (addr_out !== ea || valid !== ev) begin
      errors++;
      $display("FAIL %s addr=%h valid=%b expected addr=%h valid=%b",
               req, addr_out, valid, ea, ev);
    end
  endtask

  task automatic idle_inputs();
    cpu_stb_n = 1; ctl_stb_n = 1; adv_n = 1;
    sel_n = 0; sel_hi = 1; sel_lo_n = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic strobe(logic [AW-1:0] a, bit il, bit use_ctl);
    idle_inputs();
    addr_in = a; order_il = il;
    if (use_ctl) ctl_stb_n = 0; else cpu_stb_n = 0;
    tick();
    idle_inputs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a, ea;
    idle_inputs(); order_il = 0; addr_in = '1; rst = 1;
    @(negedge clk); tick();
    rst = 0;
    chk("R1 reset state", '0, 1'b0);

    // R10: advance with no burst
    adv_n = 0; tick(); tick();
    chk("R10 idle advance", '0, 1'b0);
    adv_n = 1;

    // Sweep: uppers, starts, orders, both strobes; walk 4 beats plus wrap.
    for (int up = 0; up < 3; up++)
      for (int s = 0; s < 4; s++)
        for (int il = 0; il < 2; il++)
          for (int st = 0; st < 2; st++) begin
            a = AW'((up * 24'h5a3c1 + 7) << 2) | AW'(s);
            a[AW-1:2] = AW'(up * 'h1d5b + 3);
            strobe(a, il[0], st[0]);
            chk(st ? "R2 ctl strobe capture" : "R2 cpu strobe capture", a, 1'b1);
            for (int k = 1; k <= 4; k++) begin
              adv_n = 0;
              if (k == 2) order_il = ~il[0]; // R11 mid-burst change ignored
              tick();
              adv_n = 1;
              ea = {a[AW-1:2], 2'(exp_low(s, k % 4, il[0]))};
              if (k == 4) chk("R8 wrap to start", ea, 1'b1);
              else chk(il ? "R5/R7/R11 interleaved beat" : "R6/R7/R11 linear beat", ea, 1'b1);
            end
          end

    // R4 hold for several cycles mid-burst
    a = 18'h2abc9;
    strobe(a, 1'b0, 1'b0);
    adv_n = 0; tick(); adv_n = 1;
    ea = {a[AW-1:2], 2'(exp_low(1, 1, 1'b0))};
    for (int i = 0; i < 5; i++) begin tick(); chk("R4 hold", ea, 1'b1); end

    // R9 restart mid burst, strobe wins over advance
    a = 18'h13572;
    adv_n = 0; cpu_stb_n = 0; addr_in = a; order_il = 1; tick(); idle_inputs();
    chk("R9 restart", a, 1'b1);
    adv_n = 0; tick(); adv_n = 1;
    chk("R9 restart then beat1", {a[AW-1:2], 2'(exp_low(2, 1, 1'b1))}, 1'b1);

    // R3 every deselecting enable combination
    for (int c = 0; c < 8; c++) begin
      if (c == 3'b010) continue; // the one selecting pattern (sel_n=0,sel_hi=1,sel_lo_n=0)
      strobe(18'h3ffff, 1'b0, 1'b0);
      chk("R3 setup", 18'h3ffff, 1'b1);
      ctl_stb_n = 0; addr_in = 18'h00005;
      sel_n = c[2]; sel_hi = c[1]; sel_lo_n = c[0];
      tick(); idle_inputs();
      chk("R3 deselected strobe", 18'h3ffff, 1'b0);
    end

    // R1 reset mid burst
    strobe(18'h0a5a7, 1'b1, 1'b1);
    rst = 1; tick(); rst = 0;
    chk("R1 reset mid burst", '0, 1'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule